// File: doc/BRIEF.md
# Program Status Register Unit

This unit holds the processor's current status word and one saved status word for each exception bank (fast interrupt, interrupt, supervisor, abort, undefined). The current word carries the condition flags N, Z, C and V in bits 31 to 28. It also carries the interrupt disable bits I (bit 7) and F (bit 6) and the five-bit mode field in bits 4:0. The mode field is driven out to the register file, which uses it to select its banked registers.

Three kinds of update reach the current word:
- **Byte-field writes** for move-to-status instructions. Which fields may be written depends on privilege and on a configuration input.
- **Full-word writes**.
- **Flag updates** from an ALU result. For arithmetic operations, carry and overflow come only from the operand and result sign bits. Logical operations update only N and Z.

Saved words are written with byte-field writes aimed at the bank of the current mode. They are read back through a separate mode select. When that mode has no saved word, the read returns the current word instead.

Top module: `psr_unit`

## Requirements
- R1: After reset the current word is 0x000000D3 (supervisor mode 0x13 with I and F set), every saved word is zero, mode_out is 0x13 and nzcv is 0.
- R2: A field write to the current word in a privileged mode replaces byte k (bits 8k+7:8k) with the write data when field_mask[k] is 1, for k = 0..3, and leaves every other byte unchanged.
- R3: When the current mode is a user mode (0x00 or 0x10), a field write to the current word changes only bits 31:24, and only when field_mask[3] is 1; mask bits 2:0 are ignored.
- R4: While cfg_wide is 0, full and field writes to the current word can change only bits 31:28, 7:6 and 4:0; all other bits keep their value.
- R5: A field write to a saved word (field_to_saved = 1) honours all four mask bits in any mode and goes to the saved word of the current mode's bank. If the current mode is user (0x00, 0x10), system (0x1F) or any other mode without a bank, the write is dropped and no saved word changes.
- R6: psr_saved returns the saved word selected by rd_mode: fast interrupt 0x01 and 0x11, interrupt 0x02 and 0x12, supervisor 0x03 and 0x13, abort 0x17, undefined 0x1B. For any other rd_mode it returns the current word.
- R7: On a flag update, N is set and Z cleared for a negative result. Z is set and N cleared for a zero result. Both are cleared otherwise.
- R8: On an arithmetic flag update with alu_sub = 0, C = (a&b)|(a&~r)|(b&~r) and V = 1 exactly when a and b are equal and r differs from them, where a, b and r are the operand and result sign bits.
- R9: On an arithmetic flag update with alu_sub = 1, C = (a&~b)|(a&~r)|(~b&~r), meaning carry is the absence of a borrow. V = 1 exactly when a differs from b and r differs from a.
- R10: A flag update with flag_arith = 0 changes only N and Z; C, V and bits 27:0 keep their value.
- R11: A full write takes precedence over a field write, and either of them discards a flag update in the same cycle. Every update is visible on psr_cur, nzcv and mode_out one cycle after the clock edge that takes it.
- R12: mode_out always equals bits 4:0 of the current word, and nzcv equals bits 31:28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 = full status word writable, 0 = legacy restriction |
| cur_wr_full | input | 1 | Write the whole current word from wr_data |
| field_wr | input | 1 | Byte-field write request |
| field_to_saved | input | 1 | Field write target: 0 current word, 1 saved word of current bank |
| field_mask | input | 4 | Byte lane enables, bit k selects bits 8k+7:8k |
| wr_data | input | 32 | Write data for full and field writes |
| flag_upd | input | 1 | Update flags from the ALU result |
| flag_arith | input | 1 | 1 = update NZCV, 0 = update N and Z only |
| alu_sub | input | 1 | 1 = subtraction, 0 = addition |
| alu_a_sign | input | 1 | Sign bit of the first ALU operand |
| alu_b_sign | input | 1 | Sign bit of the second ALU operand |
| alu_res | input | 32 | ALU result |
| rd_mode | input | 5 | Mode whose saved word is read |
| psr_cur | output | 32 | Current status word |
| psr_saved | output | 32 | Saved word for rd_mode, or current word if none |
| nzcv | output | 4 | Condition flags N, Z, C, V |
| mode_out | output | 5 | Current mode field to the register file |

## Verification
Every write and flag update passes through a single register stage, so its effect on psr_cur, nzcv and mode_out appears one cycle after the edge that captures it. The saved-word read path is combinational from rd_mode and the stored words. The bench sets inputs one time unit after a rising edge and waits for the next rising edge. It samples one time unit after that edge, so each check falls inside the cycle in which the new value is first held. Read-back of saved words is checked by changing rd_mode between edges and sampling in the same cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [2:0] {
    BK_USR  = 3'd0,
    BK_FIQ  = 3'd1,
    BK_IRQ  = 3'd2,
    BK_SVC  = 3'd3,
    BK_ABT  = 3'd4,
    BK_UND  = 3'd5,
    BK_SYS  = 3'd6,
    BK_NONE = 3'd7
  } bank_e;

  localparam int NUM_SAVED = 5;
  localparam int SLOT_W    = $clog2(NUM_SAVED);
  localparam int MODE_W    = 5;

  function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      5'h00, 5'h10: b = BK_USR;
      5'h01, 5'h11: b = BK_FIQ;
      5'h02, 5'h12: b = BK_IRQ;
      5'h03, 5'h13: b = BK_SVC;
      5'h17:        b = BK_ABT;
      5'h1B:        b = BK_UND;
      5'h1F:        b = BK_SYS;
      default:      b = BK_NONE;
    endcase
    return b;
  endfunction

  function automatic logic bank_has_saved(input bank_e b);
    return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
           (b == BK_ABT) || (b == BK_UND);
  endfunction

  function automatic logic [SLOT_W-1:0] saved_slot(input bank_e b);
    logic [SLOT_W-1:0] s;
    case (b)
      BK_FIQ:  s = SLOT_W'(0);
      BK_IRQ:  s = SLOT_W'(1);
      BK_SVC:  s = SLOT_W'(2);
      BK_ABT:  s = SLOT_W'(3);
      BK_UND:  s = SLOT_W'(4);
      default: s = SLOT_W'(0);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc #(
  parameter int W = 32
) (
  input  logic         is_sub,
  input  logic         a_sign,
  input  logic         b_sign,
  input  logic [W-1:0] res,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o
);
  logic r_sign;

  always_comb begin
    r_sign = res[W-1];
    n_o    = r_sign;
    z_o    = (res == '0);
    if (is_sub) begin
      c_o = (a_sign & ~b_sign) | (a_sign & ~r_sign) | (~b_sign & ~r_sign);
      v_o = (a_sign ^ b_sign) & (r_sign ^ a_sign);
    end else begin
      c_o = (a_sign & b_sign) | (a_sign & ~r_sign) | (b_sign & ~r_sign);
      v_o = ~(a_sign ^ b_sign) & (r_sign ^ a_sign);
    end
  end
endmodule

// File: rtl/psr_lane_mask.sv
module psr_lane_mask #(
  parameter int W     = 32,
  parameter int LANES = W / 8
) (
  input  logic [LANES-1:0] lane_req,
  input  logic             user_lock,
  input  logic             legacy_lock,
  output logic [W-1:0]     bit_mask
);
  localparam logic [W-1:0] LEGACY_KEEP = {4'hF, {(W-12){1'b0}}, 8'hDF};

  logic [W-1:0] raw_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    if (g == LANES - 1) begin : g_top
      assign lane_on = lane_req[g];
    end else begin : g_low
      assign lane_on = lane_req[g] & ~user_lock;
    end
    assign raw_mask[g*8 +: 8] = {8{lane_on}};
  end

  always_comb begin
    bit_mask = raw_mask;
    if (legacy_lock) bit_mask = raw_mask & LEGACY_KEEP;
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [W-1:0]      wr_mask,
  input  logic [W-1:0]      wr_data,
  input  logic [MODE_W-1:0] rd_mode,
  input  logic [W-1:0]      cur_word,
  output logic [W-1:0]      rd_word
);
  logic [NUM_SAVED-1:0][W-1:0] sv_q;
  logic [NUM_SAVED-1:0][W-1:0] sv_d;
  logic [NUM_SAVED-1:0]        sv_en;

  bank_e             wr_bank;
  bank_e             rd_bank;
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rd_slot;

  assign wr_bank = mode_to_bank(wr_mode);
  assign rd_bank = mode_to_bank(rd_mode);
  assign wr_slot = saved_slot(wr_bank);
  assign rd_slot = saved_slot(rd_bank);

  for (genvar g = 0; g < NUM_SAVED; g++) begin : g_word
    always_comb begin
      sv_en[g] = wr_en & bank_has_saved(wr_bank) & (wr_slot == SLOT_W'(g));
      sv_d[g]  = (sv_q[g] & ~wr_mask) | (wr_data & wr_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sv_q[g] <= '0;
      else if (sv_en[g]) sv_q[g] <= sv_d[g];
    end
  end

  always_comb begin
    rd_word = cur_word;
    if (bank_has_saved(rd_bank)) begin
      for (int i = 0; i < NUM_SAVED; i++) begin
        if (rd_slot == SLOT_W'(i)) rd_word = sv_q[i];
      end
    end
  end

  // R5
  drop_unbanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bank_has_saved(mode_to_bank(wr_mode))) |=> $stable(sv_q));

endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cur_wr_full,
  input  logic              field_wr,
  input  logic              field_to_saved,
  input  logic [3:0]        field_mask,
  input  logic [W-1:0]      wr_data,
  input  logic              flag_upd,
  input  logic              flag_arith,
  input  logic              alu_sub,
  input  logic              alu_a_sign,
  input  logic              alu_b_sign,
  input  logic [W-1:0]      alu_res,
  input  logic [MODE_W-1:0] rd_mode,
  output logic [W-1:0]      psr_cur,
  output logic [W-1:0]      psr_saved,
  output logic [3:0]        nzcv,
  output logic [MODE_W-1:0] mode_out
);
  localparam int           LANES   = W / 8;
  localparam int           N_POS   = W - 1;
  localparam int           Z_POS   = W - 2;
  localparam int           C_POS   = W - 3;
  localparam int           V_POS   = W - 4;
  localparam logic [W-1:0] RST_VAL = W'(32'h0000_00D3);

  logic [W-1:0] cur_q;
  logic [W-1:0] cur_d;
  logic         cur_en;
  logic         in_user;
  logic         cur_field;
  logic [LANES-1:0] cur_lanes;
  logic [W-1:0] cur_mask;
  logic [W-1:0] sv_mask;
  logic         sv_wr;
  logic         f_n, f_z, f_c, f_v;

  assign in_user   = (mode_to_bank(cur_q[MODE_W-1:0]) == BK_USR);
  assign cur_field = field_wr & ~field_to_saved;
  assign sv_wr     = field_wr & field_to_saved;
  assign cur_lanes = cur_wr_full ? {LANES{1'b1}} : field_mask;

  psr_lane_mask #(.W(W), .LANES(LANES)) u_cur_mask (
    .lane_req    (cur_lanes),
    .user_lock   (in_user & ~cur_wr_full),
    .legacy_lock (~cfg_wide),
    .bit_mask    (cur_mask)
  );

  psr_lane_mask #(.W(W), .LANES(LANES)) u_sv_mask (
    .lane_req    (field_mask),
    .user_lock   (1'b0),
    .legacy_lock (1'b0),
    .bit_mask    (sv_mask)
  );

  psr_flag_calc #(.W(W)) u_flags (
    .is_sub (alu_sub),
    .a_sign (alu_a_sign),
    .b_sign (alu_b_sign),
    .res    (alu_res),
    .n_o    (f_n),
    .z_o    (f_z),
    .c_o    (f_c),
    .v_o    (f_v)
  );

  always_comb begin
    cur_en = cur_wr_full | cur_field | flag_upd;
    cur_d  = cur_q;
    if (cur_wr_full || cur_field) begin
      cur_d = (cur_q & ~cur_mask) | (wr_data & cur_mask);
    end else if (flag_upd) begin
      cur_d[N_POS] = f_n;
      cur_d[Z_POS] = f_z;
      if (flag_arith) begin
        cur_d[C_POS] = f_c;
        cur_d[V_POS] = f_v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= RST_VAL;
    else if (cur_en) cur_q <= cur_d;
  end

  psr_saved_bank #(.W(W)) u_saved (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sv_wr),
    .wr_mode  (cur_q[MODE_W-1:0]),
    .wr_mask  (sv_mask),
    .wr_data  (wr_data),
    .rd_mode  (rd_mode),
    .cur_word (cur_q),
    .rd_word  (psr_saved)
  );

  assign psr_cur  = cur_q;
  assign nzcv     = cur_q[W-1:W-4];
  assign mode_out = cur_q[MODE_W-1:0];

  // R3
  user_lowbytes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_user && cur_field && !cur_wr_full) |=> (cur_q[W-9:0] == $past(cur_q[W-9:0])));

  // R4
  legacy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wide) |=> ((cur_q[W-5:8] == $past(cur_q[W-5:8])) && (cur_q[5] == $past(cur_q[5]))));

  // R7
  nz_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !cur_wr_full && !cur_field) |=> !(cur_q[N_POS] && cur_q[Z_POS]));

  // R8
  add_mixed_sign_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && flag_arith && !alu_sub && (alu_a_sign != alu_b_sign) && !cur_wr_full && !cur_field)
      |=> !cur_q[V_POS]);

  // R10
  logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !flag_arith && !cur_wr_full && !cur_field)
      |=> (cur_q[C_POS:0] == $past(cur_q[C_POS:0])));

endmodule

// File: tb/tb_psr_unit.sv
`timescale 1ns/1ps
module tb_psr_unit;
  logic        clk;
  logic        rst_n;
  logic        cfg_wide;
  logic        cur_wr_full;
  logic        field_wr;
  logic        field_to_saved;
  logic [3:0]  field_mask;
  logic [31:0] wr_data;
  logic        flag_upd;
  logic        flag_arith;
  logic        alu_sub;
  logic        alu_a_sign;
  logic        alu_b_sign;
  logic [31:0] alu_res;
  logic [4:0]  rd_mode;
  logic [31:0] psr_cur;
  logic [31:0] psr_saved;
  logic [3:0]  nzcv;
  logic [4:0]  mode_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  psr_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cur_wr_full(cur_wr_full),
    .field_wr(field_wr), .field_to_saved(field_to_saved), .field_mask(field_mask),
    .wr_data(wr_data), .flag_upd(flag_upd), .flag_arith(flag_arith),
    .alu_sub(alu_sub), .alu_a_sign(alu_a_sign), .alu_b_sign(alu_b_sign),
    .alu_res(alu_res), .rd_mode(rd_mode), .psr_cur(psr_cur),
    .psr_saved(psr_saved), .nzcv(nzcv), .mode_out(mode_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    cur_wr_full = 0; field_wr = 0; field_to_saved = 0; field_mask = 4'h0;
    wr_data = '0; flag_upd = 0; flag_arith = 0; alu_sub = 0;
    alu_a_sign = 0; alu_b_sign = 0; alu_res = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic full_wr(input logic [31:0] d);
    idle(); cur_wr_full = 1; wr_data = d; tick();
  endtask

  task automatic fld_wr(input logic sv, input logic [3:0] m, input logic [31:0] d);
    idle(); field_wr = 1; field_to_saved = sv; field_mask = m; wr_data = d; tick();
  endtask

  task automatic flags(input logic ar, input logic sb, input logic a, input logic b,
                       input logic [31:0] r);
    idle(); flag_upd = 1; flag_arith = ar; alu_sub = sb;
    alu_a_sign = a; alu_b_sign = b; alu_res = r; tick();
  endtask

  task automatic read_saved(input string req, input logic [4:0] m, input logic [31:0] exp);
    rd_mode = m; #1;
    chk(req, psr_saved, exp);
  endtask

  task automatic t_reset();
    chk("R1 cur", psr_cur, 32'h0000_00D3);
    chk("R1 mode", {27'd0, mode_out}, 32'h13);
    chk("R1 nzcv", {28'd0, nzcv}, 32'h0);
    read_saved("R1 svc saved", 5'h13, 32'h0);
    read_saved("R1 und saved", 5'h1B, 32'h0);
  endtask

  task automatic t_field_priv();
    fld_wr(0, 4'b0101, 32'h1234_5693);
    chk("R2 lanes 0,2", psr_cur, 32'h0034_0093);
    fld_wr(0, 4'b1010, 32'hF0A5_7700);
    chk("R2 lanes 1,3", psr_cur, 32'hF034_7793);
    chk("R12 nzcv", {28'd0, nzcv}, 32'hF);
    chk("R12 mode", {27'd0, mode_out}, 32'h13);
  endtask

  task automatic t_saved_banks();
    fld_wr(1, 4'b1111, 32'hCAFE_0011);
    chk("R5 cur untouched", psr_cur, 32'hF034_7793);
    read_saved("R6 svc 0x13", 5'h13, 32'hCAFE_0011);
    read_saved("R6 svc 0x03", 5'h03, 32'hCAFE_0011);
    full_wr(32'h0000_0092);
    chk("R11 full write", psr_cur, 32'h0000_0092);
    fld_wr(1, 4'b0011, 32'h1234_5678);
    read_saved("R5 irq partial", 5'h12, 32'h0000_5678);
    read_saved("R6 irq 0x02", 5'h02, 32'h0000_5678);
    read_saved("R6 svc kept", 5'h13, 32'hCAFE_0011);
  endtask

  task automatic t_user();
    full_wr(32'h0000_0010);
    chk("R11 to user", {27'd0, mode_out}, 32'h10);
    fld_wr(0, 4'b1111, 32'hA5C3_B2D3);
    chk("R3 user flags only", psr_cur, 32'hA500_0010);
    fld_wr(0, 4'b0111, 32'hFFFF_FFFF);
    chk("R3 user low lanes ignored", psr_cur, 32'hA500_0010);
    fld_wr(1, 4'b1111, 32'h5555_5555);
    read_saved("R5 user drop fiq", 5'h11, 32'h0);
    read_saved("R5 user drop irq", 5'h12, 32'h0000_5678);
    read_saved("R5 user drop svc", 5'h13, 32'hCAFE_0011);
    read_saved("R5 user drop abt", 5'h17, 32'h0);
    read_saved("R5 user drop und", 5'h1B, 32'h0);
    read_saved("R6 usr fallback", 5'h10, 32'hA500_0010);
    read_saved("R6 sys fallback", 5'h1F, 32'hA500_0010);
    read_saved("R6 dummy fallback", 5'h05, 32'hA500_0010);
    full_wr(32'h0000_001F);
    fld_wr(1, 4'b1111, 32'h7777_7777);
    read_saved("R5 sys drop svc", 5'h13, 32'hCAFE_0011);
    read_saved("R5 sys drop fiq", 5'h11, 32'h0);
    full_wr(32'h0000_0010);
  endtask

  task automatic t_flags();
    flags(1, 0, 0, 0, 32'h8000_0000);
    chk("R8 add pos+pos ovf", {28'd0, nzcv}, 32'h9);
    chk("R7 other bits kept", psr_cur & 32'h0FFF_FFFF, 32'h0000_0010);
    flags(1, 0, 1, 0, 32'h0000_0000);
    chk("R8 add carry zero", {28'd0, nzcv}, 32'h6);
    flags(1, 0, 1, 1, 32'h0000_0000);
    chk("R8 add neg+neg ovf", {28'd0, nzcv}, 32'h7);
    flags(1, 1, 0, 0, 32'h0000_0002);
    chk("R9 sub no borrow", {28'd0, nzcv}, 32'h2);
    flags(1, 1, 0, 0, 32'hFFFF_FFFE);
    chk("R9 sub borrow", {28'd0, nzcv}, 32'h8);
    flags(1, 1, 1, 0, 32'h7FFF_FFFF);
    chk("R9 sub neg-pos ovf", {28'd0, nzcv}, 32'h3);
    flags(1, 1, 0, 1, 32'h8000_0000);
    chk("R9 sub pos-neg ovf", {28'd0, nzcv}, 32'h9);
    flags(0, 0, 1, 1, 32'h0000_0000);
    chk("R10 logic zero keeps CV", {28'd0, nzcv}, 32'h5);
    flags(0, 1, 0, 0, 32'h0000_0040);
    chk("R7 positive clears NZ", {28'd0, nzcv}, 32'h1);
    chk("R10 low bits kept", psr_cur, 32'h1000_0010);
  endtask

  task automatic t_priority();
    idle(); cur_wr_full = 1; wr_data = 32'h0000_00D3;
    field_wr = 1; field_mask = 4'b1000; wr_data = 32'h0000_00D3;
    flag_upd = 1; flag_arith = 1; alu_res = 32'h0;
    tick();
    chk("R11 full over flag", psr_cur, 32'h0000_00D3);
    idle(); field_wr = 1; field_mask = 4'b1000; wr_data = 32'h3000_0000;
    flag_upd = 1; flag_arith = 1; alu_res = 32'h8000_0000;
    tick();
    chk("R11 field over flag", psr_cur, 32'h3000_00D3);
  endtask

  task automatic t_legacy();
    fld_wr(0, 4'b0110, 32'h00AB_CD00);
    chk("R2 middle lanes", psr_cur, 32'h30AB_CDD3);
    cfg_wide = 0;
    fld_wr(0, 4'b1111, 32'hC500_0024);
    chk("R4 legacy field", psr_cur, 32'hC0AB_CD04);
    full_wr(32'h0F00_FF33);
    chk("R4 legacy full", psr_cur, 32'h00AB_CD13);
    cfg_wide = 1;
    full_wr(32'h0F00_FF33);
    chk("R4 wide again", psr_cur, 32'h0F00_FF33);
  endtask

  initial begin
    idle();
    cfg_wide = 1;
    rd_mode  = 5'h13;
    rst_n    = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_field_priv();
    t_saved_banks();
    t_user();
    t_flags();
    t_priority();
    t_legacy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule